// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This unit sits beside the program-counter logic of a 32-bit in-order core that has branch delay slots. When the pipeline raises an exception request, the unit sorts the cause number into a class. It then computes the saved program counter for that class, saves the current status word, and produces a status word with the delay-slot flag updated. It also forms the handler address and issues a one-cycle redirect to the fetch stage.

A return-from-exception strobe reverses the entry. The status word is rebuilt from the saved copy with its fixed-one bit forced high, and fetch is redirected to the saved program counter. A trap cause does not enter a handler; it raises a debug-halt pulse. A cause number outside the known set raises a sticky error flag.

All outputs are registered. Each effect appears on the outputs in the cycle after the request is sampled.

Top module: `exc_unit`

## Requirements
- R1: A request with cause 0xE (trap) gives a one-cycle `halt_o` pulse in the next cycle. It produces no redirect and no status update, and it leaves `epcr_o` and `esr_o` unchanged.
- R2: For cause 0xC (system call) and cause 0xD (floating point), `epcr_o` becomes PC+4. If `in_dslot_i` is 1, it becomes PC instead.
- R3: For cause 0x2 (bus error), 0x6 (alignment), 0x7 (illegal instruction) and 0xB (range), `epcr_o` becomes PC. If `in_dslot_i` is 1, it becomes PC-4.
- R4: Cause 0x1 (reset) leaves `epcr_o` unchanged but still saves the status word and redirects.
- R5: On any handler entry, `esr_o` becomes `sr_i`. `sr_new_o` becomes `sr_i` with bit 13 (delay-slot flag) replaced by `in_dslot_i`, and `sr_new_valid_o` pulses.
- R6: On handler entry, the next cycle shows `redirect_valid_o`=1 with `redirect_pc_o` = (cause << 8) + (0xF0000000 if `sr_i` bit 14 is 1, else 0).
- R7: A return strobe with no exception request sets `sr_new_o` = `esr_o` with bit 15 forced to 1 and pulses `sr_new_valid_o`. It also redirects to the value `epcr_o` held when the strobe was sampled.
- R8: `clr_dslot_o` pulses for one cycle after every handler entry and every accepted return, and at no other time.
- R9: Any other cause number sets `cause_err_o`, which stays set until reset. Such a cause produces no redirect and changes neither `epcr_o` nor `esr_o`.
- R10: When an exception request and a return strobe arrive in the same cycle, the request is served and the return is dropped, whatever the cause class.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_req_i | input | 1 | Exception request strobe |
| exc_cause_i | input | 4 | Cause number |
| exc_pc_i | input | 32 | PC of the faulting instruction |
| in_dslot_i | input | 1 | Faulting instruction sat in a delay slot |
| sr_i | input | 32 | Current status word |
| rfe_i | input | 1 | Return-from-exception strobe |
| redirect_valid_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | 32 | Redirect target |
| epcr_o | output | 32 | Saved program counter |
| esr_o | output | 32 | Saved status word |
| sr_new_o | output | 32 | Status word to install |
| sr_new_valid_o | output | 1 | Install pulse for `sr_new_o` |
| halt_o | output | 1 | Debug-halt pulse for trap |
| clr_dslot_o | output | 1 | Clear pending next-delay-slot state |
| cause_err_o | output | 1 | Sticky unknown-cause flag |

## Verification
An exception request and a return strobe can land in the same cycle. The bench drives that collision with a vectoring cause, with a trap and with an unknown cause, each time after the saved registers already hold known values.

The check confirms three things. The redirect target is the handler vector rather than the saved PC. The saved registers follow the exception rule only. For trap and unknown causes, no redirect and no status install appear at all. The same per-cycle reference model that judges the single events also judges these collisions.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned CAUSE_W = 4;

  localparam logic [CAUSE_W-1:0] C_RESET = 4'h1;
  localparam logic [CAUSE_W-1:0] C_BUS   = 4'h2;
  localparam logic [CAUSE_W-1:0] C_ALIGN = 4'h6;
  localparam logic [CAUSE_W-1:0] C_ILL   = 4'h7;
  localparam logic [CAUSE_W-1:0] C_RANGE = 4'hB;
  localparam logic [CAUSE_W-1:0] C_SYS   = 4'hC;
  localparam logic [CAUSE_W-1:0] C_FP    = 4'hD;
  localparam logic [CAUSE_W-1:0] C_TRAP  = 4'hE;

  // AFTER: resume past the faulting insn; AT: re-execute it
  typedef enum logic [2:0] {
    CLS_BAD,
    CLS_RESET,
    CLS_AFTER,
    CLS_AT,
    CLS_TRAP
  } exc_cls_e;
endpackage

// File: rtl/exc_cause_dec.sv
module exc_cause_dec
  import exc_pkg::*;
(
  input  logic [CAUSE_W-1:0] cause_i,
  output exc_cls_e           cls_o
);
  always_comb begin
    case (cause_i)
      C_RESET:                        cls_o = CLS_RESET;
      C_SYS, C_FP:                    cls_o = CLS_AFTER;
      C_BUS, C_ALIGN, C_ILL, C_RANGE: cls_o = CLS_AT;
      C_TRAP:                         cls_o = CLS_TRAP;
      default:                        cls_o = CLS_BAD;
    endcase
  end
endmodule

// File: rtl/exc_epc_calc.sv
module exc_epc_calc
  import exc_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  exc_cls_e          cls_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              dslot_i,
  output logic [XLEN-1:0]   epc_o,
  output logic              load_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  always_comb begin
    epc_o  = pc_i;
    load_o = 1'b0;
    case (cls_i)
      CLS_AFTER: begin
        load_o = 1'b1;
        epc_o  = dslot_i ? pc_i : pc_i + STEP;
      end
      CLS_AT: begin
        load_o = 1'b1;
        epc_o  = dslot_i ? pc_i - STEP : pc_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen
  import exc_pkg::*;
#(
  parameter int unsigned     XLEN      = 32,
  parameter int unsigned     VEC_SHIFT = 8,
  parameter logic [XLEN-1:0] HI_BASE   = 32'hF000_0000
) (
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               hi_sel_i,
  output logic [XLEN-1:0]    vec_o
);
  localparam int unsigned     OFF_W    = VEC_SHIFT + CAUSE_W;
  localparam logic [XLEN-1:0] OFF_MASK = (XLEN'(1) << OFF_W) - XLEN'(1);

  logic [XLEN-1:0] off;
  assign off = XLEN'(cause_i) << VEC_SHIFT;

  // Base with clear low bits needs only an OR, no carry chain
  if ((HI_BASE & OFF_MASK) == '0) begin : g_or
    assign vec_o = hi_sel_i ? (HI_BASE | off) : off;
  end else begin : g_add
    assign vec_o = hi_sel_i ? (HI_BASE + off) : off;
  end
endmodule

// File: rtl/exc_unit.sv
module exc_unit
  import exc_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter int unsigned     VEC_SHIFT  = 8,
  parameter logic [XLEN-1:0] HI_BASE    = 32'hF000_0000,
  parameter int unsigned     INSN_BYTES = 4,
  parameter int unsigned     DSX_BIT    = 13,
  parameter int unsigned     EPH_BIT    = 14,
  parameter int unsigned     FO_BIT     = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exc_req_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic [XLEN-1:0]    exc_pc_i,
  input  logic               in_dslot_i,
  input  logic [XLEN-1:0]    sr_i,
  input  logic               rfe_i,
  output logic               redirect_valid_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic [XLEN-1:0]    epcr_o,
  output logic [XLEN-1:0]    esr_o,
  output logic [XLEN-1:0]    sr_new_o,
  output logic               sr_new_valid_o,
  output logic               halt_o,
  output logic               clr_dslot_o,
  output logic               cause_err_o
);
  exc_cls_e        cls;
  logic [XLEN-1:0] epc_val;
  logic            epc_load;
  logic [XLEN-1:0] vec;
  logic [XLEN-1:0] sr_entry;
  logic [XLEN-1:0] sr_return;
  logic            entry, trap_hit, bad_hit, rfe_go;

  exc_cause_dec u_dec (
    .cause_i (exc_cause_i),
    .cls_o   (cls)
  );

  exc_epc_calc #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_epc (
    .cls_i   (cls),
    .pc_i    (exc_pc_i),
    .dslot_i (in_dslot_i),
    .epc_o   (epc_val),
    .load_o  (epc_load)
  );

  exc_vec_gen #(.XLEN(XLEN), .VEC_SHIFT(VEC_SHIFT), .HI_BASE(HI_BASE)) u_vec (
    .cause_i  (exc_cause_i),
    .hi_sel_i (sr_i[EPH_BIT]),
    .vec_o    (vec)
  );

  assign entry    = exc_req_i && (cls inside {CLS_RESET, CLS_AFTER, CLS_AT});
  assign trap_hit = exc_req_i && (cls == CLS_TRAP);
  assign bad_hit  = exc_req_i && (cls == CLS_BAD);
  assign rfe_go   = rfe_i && !exc_req_i;

  always_comb begin
    sr_entry          = sr_i;
    sr_entry[DSX_BIT] = in_dslot_i;
    sr_return         = esr_o;
    sr_return[FO_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_valid_o <= 1'b0;
      redirect_pc_o    <= '0;
      epcr_o           <= '0;
      esr_o            <= '0;
      sr_new_o         <= '0;
      sr_new_valid_o   <= 1'b0;
      halt_o           <= 1'b0;
      clr_dslot_o      <= 1'b0;
      cause_err_o      <= 1'b0;
    end else begin
      redirect_valid_o <= entry || rfe_go;
      sr_new_valid_o   <= entry || rfe_go;
      clr_dslot_o      <= entry || rfe_go;
      halt_o           <= trap_hit;
      if (bad_hit) cause_err_o <= 1'b1;
      if (entry) begin
        redirect_pc_o <= vec;
        esr_o         <= sr_i;
        sr_new_o      <= sr_entry;
        if (epc_load) epcr_o <= epc_val;
      end else if (rfe_go) begin
        redirect_pc_o <= epcr_o;
        sr_new_o      <= sr_return;
      end
    end
  end
endmodule

// File: rtl/exc_unit_chk.sv
module exc_unit_chk
  import exc_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned VEC_SHIFT = 8,
  parameter int unsigned DSX_BIT   = 13,
  parameter int unsigned FO_BIT    = 15
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               exc_req_i,
  input logic [CAUSE_W-1:0] exc_cause_i,
  input logic [XLEN-1:0]    exc_pc_i,
  input logic               in_dslot_i,
  input logic [XLEN-1:0]    sr_i,
  input logic               rfe_i,
  input logic               redirect_valid_o,
  input logic [XLEN-1:0]    redirect_pc_o,
  input logic [XLEN-1:0]    epcr_o,
  input logic [XLEN-1:0]    esr_o,
  input logic [XLEN-1:0]    sr_new_o,
  input logic               sr_new_valid_o,
  input logic               halt_o,
  input logic               clr_dslot_o,
  input logic               cause_err_o
);
  logic vect_req;
  assign vect_req = exc_req_i && (exc_cause_i == C_RESET || exc_cause_i == C_BUS ||
                    exc_cause_i == C_ALIGN || exc_cause_i == C_ILL ||
                    exc_cause_i == C_RANGE || exc_cause_i == C_SYS || exc_cause_i == C_FP);

  AST_TRAP_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i && exc_cause_i == C_TRAP |=> halt_o && !redirect_valid_o && $stable(epcr_o) && $stable(esr_o)); // R1

  AST_SYS_EPCR_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i && exc_cause_i == C_SYS && !in_dslot_i |=> epcr_o == $past(exc_pc_i) + XLEN'(4)); // R2

  AST_RESET_KEEPS_EPCR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i && exc_cause_i == C_RESET |=> $stable(epcr_o) && redirect_valid_o); // R4

  AST_ENTRY_SAVES_SR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vect_req |=> esr_o == $past(sr_i) && sr_new_o[DSX_BIT] == $past(in_dslot_i)); // R5

  AST_VEC_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vect_req |=> redirect_pc_o[VEC_SHIFT-1:0] == '0); // R6

  AST_RFE_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfe_i && !exc_req_i |=> redirect_pc_o == $past(epcr_o) && sr_new_o[FO_BIT]); // R7

  AST_CLR_WITH_INSTALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_new_valid_o |-> clr_dslot_o); // R8

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_err_o |=> cause_err_o); // R9

  AST_REQ_BEATS_RFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i && rfe_i && !vect_req |=> !redirect_valid_o); // R10
endmodule

bind exc_unit exc_unit_chk #(
  .XLEN(XLEN), .VEC_SHIFT(VEC_SHIFT), .DSX_BIT(DSX_BIT), .FO_BIT(FO_BIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .exc_req_i(exc_req_i), .exc_cause_i(exc_cause_i),
  .exc_pc_i(exc_pc_i), .in_dslot_i(in_dslot_i), .sr_i(sr_i), .rfe_i(rfe_i),
  .redirect_valid_o(redirect_valid_o), .redirect_pc_o(redirect_pc_o), .epcr_o(epcr_o),
  .esr_o(esr_o), .sr_new_o(sr_new_o), .sr_new_valid_o(sr_new_valid_o), .halt_o(halt_o),
  .clr_dslot_o(clr_dslot_o), .cause_err_o(cause_err_o)
);

// File: tb/exc_unit_tb_top.sv
`timescale 1ns/1ps
module exc_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        exc_req_i = 1'b0;
  logic [3:0]  exc_cause_i = '0;
  logic [31:0] exc_pc_i = '0;
  logic        in_dslot_i = 1'b0;
  logic [31:0] sr_i = '0;
  logic        rfe_i = 1'b0;
  logic        redirect_valid_o, sr_new_valid_o, halt_o, clr_dslot_o, cause_err_o;
  logic [31:0] redirect_pc_o, epcr_o, esr_o, sr_new_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_epcr = '0, m_esr = '0, m_pc = '0, m_sr = '0;
  logic        m_err = 1'b0, m_rv = 1'b0, m_halt = 1'b0;

  exc_unit dut_i (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "redirect_valid", 32'(redirect_valid_o), 32'(m_rv));
    chk(tag, "sr_new_valid",   32'(sr_new_valid_o),   32'(m_rv));
    chk(tag, "clr_dslot",      32'(clr_dslot_o),      32'(m_rv));
    chk(tag, "halt",           32'(halt_o),           32'(m_halt));
    chk(tag, "cause_err",      32'(cause_err_o),      32'(m_err));
    chk(tag, "redirect_pc",    redirect_pc_o,         m_pc);
    chk(tag, "epcr",           epcr_o,                m_epcr);
    chk(tag, "esr",            esr_o,                 m_esr);
    chk(tag, "sr_new",         sr_new_o,              m_sr);
  endtask

  // called at a negedge; drives, predicts, then checks at the next negedge
  task automatic step(input logic req, input logic [3:0] cause, input logic [31:0] pc,
                      input logic ds, input logic [31:0] sr, input logic rfe, input string tag);
    exc_req_i = req; exc_cause_i = cause; exc_pc_i = pc;
    in_dslot_i = ds; sr_i = sr; rfe_i = rfe;
    m_rv = 1'b0; m_halt = 1'b0;
    if (req) begin
      if (cause inside {4'h1, 4'h2, 4'h6, 4'h7, 4'hB, 4'hC, 4'hD}) begin
        m_rv  = 1'b1;
        m_pc  = (32'(cause) << 8) + (sr[14] ? 32'hF000_0000 : 32'h0);
        m_esr = sr;
        m_sr  = sr;
        m_sr[13] = ds;
        if (cause inside {4'hC, 4'hD}) m_epcr = ds ? pc : pc + 32'd4;
        else if (cause != 4'h1)        m_epcr = ds ? pc - 32'd4 : pc;
      end else if (cause == 4'hE) begin
        m_halt = 1'b1;
      end else begin
        m_err = 1'b1;
      end
    end else if (rfe) begin
      m_rv = 1'b1;
      m_pc = m_epcr;
      m_sr = m_esr | 32'h0000_8000;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    compare_all(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 4'h0, 32'h0, 1'b0, 32'h0, 1'b0, tag);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    exc_req_i = 1'b0; rfe_i = 1'b0;
    m_epcr = '0; m_esr = '0; m_pc = '0; m_sr = '0;
    m_err = 1'b0; m_rv = 1'b0; m_halt = 1'b0;
    repeat (2) @(negedge clk_i);
    compare_all("R11");
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    compare_all("R11");
    // R2: system call / floating point
    step(1, 4'hC, 32'h0000_1000, 0, 32'h0000_0005, 0, "R2");
    step(1, 4'hD, 32'h0000_2000, 1, 32'h0000_0003, 0, "R2");
    step(1, 4'hD, 32'h0000_2100, 0, 32'h0000_2001, 0, "R2");
    // R3: re-execute class
    step(1, 4'h2, 32'h0000_3000, 0, 32'h0000_0011, 0, "R3");
    step(1, 4'h7, 32'h0000_3008, 1, 32'h0000_0000, 0, "R3");
    step(1, 4'h6, 32'h0000_3010, 1, 32'h0000_2000, 0, "R3");
    step(1, 4'hB, 32'h0000_3020, 0, 32'h0000_0000, 0, "R3");
    // R5: delay-slot flag replacement both ways
    step(1, 4'h7, 32'h0000_4000, 1, 32'h1234_0000, 0, "R5");
    step(1, 4'h7, 32'h0000_4004, 0, 32'h1234_2000, 0, "R5");
    // R6: high vector base
    step(1, 4'h7, 32'h0000_5000, 0, 32'h0000_4000, 0, "R6");
    step(1, 4'hC, 32'h0000_5004, 0, 32'hFFFF_FFFF, 0, "R6");
    idle("R8");
    // R4: reset cause keeps saved PC
    step(1, 4'h1, 32'h0000_6000, 0, 32'h0000_0042, 0, "R4");
    // R1: trap
    step(1, 4'hE, 32'h0000_7000, 1, 32'hAAAA_5555, 0, "R1");
    idle("R1");
    // R7: return
    step(1, 4'h2, 32'h0000_8000, 0, 32'h0000_0101, 0, "R7");
    step(0, 4'h0, 32'h0, 0, 32'h0, 1, "R7");
    step(0, 4'h0, 32'h0, 0, 32'h0, 1, "R8");
    idle("R8");
    // R10: collisions
    step(1, 4'hC, 32'h0000_9000, 0, 32'h0000_4000, 1, "R10");
    step(1, 4'hE, 32'h0000_9100, 0, 32'h0000_0000, 1, "R10");
    step(1, 4'h5, 32'h0000_9200, 0, 32'h0000_0000, 1, "R10");
    // R9: unknown causes, sticky
    step(1, 4'h0, 32'h0000_A000, 0, 32'h0000_0077, 0, "R9");
    step(1, 4'hF, 32'h0000_A004, 1, 32'h0000_0077, 0, "R9");
    idle("R9");
    step(1, 4'hB, 32'h0000_A100, 1, 32'h0000_0000, 0, "R9");
    do_reset();
    idle("R9");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule